// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block sits between a synchronous host and an asynchronous parallel ROM that offers fast reads within an open page. The host presents a byte address, a byte/word flag and a valid/ready handshake. The controller drives the ROM address lines, chip enable, output enable and the width-select pin. After a wait counted in system-clock cycles, it returns the data with a one-cycle valid strobe.

A page is four 16-bit words, or eight bytes. The controller remembers the page that is open. A read hits the page when chip enable is still low, the upper word-address bits are the same and the width mode is the same. A hit uses the short wait; anything else uses the long wait. Both waits are access times rounded up to whole clock cycles.

In byte mode the ROM's top data pin becomes an input that carries the least significant byte-address bit. The controller drives that pin and returns only the low byte. When the ROM has sat idle for a set number of cycles, the controller raises chip enable to put it into standby, and this closes the page.

Top module: `prom_page_rd`

## Requirements
- R1: During and after reset, rom_ce_n and rom_oe_n are 1, rom_byte_n is 1, rom_dq15_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the cycle in which rsp_valid is 1.
- R3: A read that misses the page raises rsp_valid exactly RAND_CYC = ceil(RAND_ACC_PS / CLK_PERIOD_PS) cycles after the accepting edge.
- R4: A read that hits the page raises rsp_valid exactly PAGE_CYC = ceil(PAGE_ACC_PS / CLK_PERIOD_PS) cycles after the accepting edge. A hit needs rom_ce_n still 0, the same req_addr[19:3] as the previous read and the same req_byte.
- R5: A change of req_byte between two reads forces the long wait, even within the same page.
- R6: In word mode (req_byte = 0), rom_addr = req_addr[19:1], rom_byte_n = 1, rom_dq15_oe = 0, and rsp_data is the full 16-bit rom_dq_in.
- R7: In byte mode (req_byte = 1), rom_addr = req_addr[19:1], rom_byte_n = 0, rom_dq15_oe = 1, rom_dq15_out = req_addr[0], and rsp_data = {8'h00, rom_dq_in[7:0]}.
- R8: After IDLE_LIMIT ready cycles with no request, rom_ce_n and rom_oe_n go to 1 and the next read takes the long wait. A request taken within IDLE_LIMIT cycles of the response keeps the page open.
- R9: Each accepted request produces exactly one rsp_valid pulse, one cycle long.
- R10: While a read is waiting, rom_addr, rom_ce_n, rom_byte_n and rom_dq15_out do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 20 | Byte address (bit 0 unused in word mode) |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 16 | Read data (upper byte zero in byte mode) |
| rom_addr | output | 19 | ROM word address lines |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM width select: 0 byte mode, 1 word mode |
| rom_dq15_out | output | 1 | Value driven on the top data pin in byte mode |
| rom_dq15_oe | output | 1 | Drive enable for the top data pin |
| rom_dq_in | input | 16 | ROM data pins as seen by the controller |

## Verification
The bench builds the controller with a 5000 ps clock and the slower supply grade's access times: RAND_ACC_PS = 120000 and PAGE_ACC_PS = 50000, which gives 24-cycle and 10-cycle waits. It sets IDLE_LIMIT to 4, so that both standby and a hit at exactly the last idle cycle can be reached in a few cycles. The ROM model returns data only once the upper and lower address have each been stable for their access time. A wait that is one cycle short, or an address that moves during a wait, therefore shows up as corrupt data.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} rd_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/prom_page_track.sv
module prom_page_track #(
  parameter int UPPER_W = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               clear,
  input  logic [UPPER_W-1:0] upper_in,
  input  logic               mode_in,
  output logic               hit,
  output logic               open_q
);
  logic [UPPER_W-1:0] upper_q;
  logic               mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      upper_q <= '0;
      mode_q  <= 1'b0;
    end else if (load) begin
      open_q  <= 1'b1;
      upper_q <= upper_in;
      mode_q  <= mode_in;
    end else if (clear) begin
      open_q  <= 1'b0;
    end
  end

  assign hit = open_q && (upper_q == upper_in) && (mode_q == mode_in);

  // R4: a loaded page is open afterwards
  a_r4_load_opens: assert property (@(posedge clk) disable iff (rst)
    load |=> open_q);
endmodule

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
  parameter int MAX_CYC = 20,
  localparam int CNT_W  = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] left,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (rst)            left <= '0;
    else if (load)      left <= load_val;
    else if (left != 0) left <= left - 1'b1;
  end

  assign done = (left == CNT_W'(1));

  // R3: the count never exceeds the long wait
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    left <= CNT_W'(MAX_CYC));
endmodule

// File: rtl/prom_idle_timer.sv
module prom_idle_timer #(
  parameter int LIMIT   = 16,
  localparam int CNT_W  = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expire = arm && (cnt == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/prom_page_rd.sv
module prom_page_rd #(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16,
  parameter int PAGE_BITS     = 2,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int RAND_ACC_PS   = 100000,
  parameter int PAGE_ACC_PS   = 30000,
  parameter int IDLE_LIMIT    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_byte,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-2:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_byte_n,
  output logic              rom_dq15_out,
  output logic              rom_dq15_oe,
  input  logic [DATA_W-1:0] rom_dq_in
);
  import prom_pkg::*;

  localparam int WADDR_W  = ADDR_W - 1;
  localparam int UPPER_W  = WADDR_W - PAGE_BITS;
  localparam int BYTE_W   = DATA_W / 2;
  localparam int RAND_CYC = ceil_div(RAND_ACC_PS, CLK_PERIOD_PS);
  localparam int PAGE_CYC = ceil_div(PAGE_ACC_PS, CLK_PERIOD_PS);
  localparam int CNT_W    = $clog2(RAND_CYC + 1);

  rd_state_e        state;
  logic             accept, hit, page_open, done, idle_exp;
  logic [CNT_W-1:0] wait_left;

  assign accept = req_valid && req_ready;

  prom_page_track #(.UPPER_W(UPPER_W)) u_track (
    .clk(clk), .rst(rst), .load(accept), .clear(idle_exp),
    .upper_in(req_addr[ADDR_W-1 -: UPPER_W]), .mode_in(req_byte),
    .hit(hit), .open_q(page_open)
  );

  prom_wait_timer #(.MAX_CYC(RAND_CYC)) u_wait (
    .clk(clk), .rst(rst), .load(accept),
    .load_val(hit ? CNT_W'(PAGE_CYC) : CNT_W'(RAND_CYC)),
    .left(wait_left), .done(done)
  );

  prom_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk(clk), .rst(rst),
    .arm(state == ST_IDLE && !rom_ce_n && !accept),
    .expire(idle_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      req_ready    <= 1'b1;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rom_addr     <= '0;
      rom_ce_n     <= 1'b1;
      rom_oe_n     <= 1'b1;
      rom_byte_n   <= 1'b1;
      rom_dq15_out <= 1'b0;
      rom_dq15_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        state        <= ST_WAIT;
        req_ready    <= 1'b0;
        rom_addr     <= req_addr[ADDR_W-1:1];
        rom_ce_n     <= 1'b0;
        rom_oe_n     <= 1'b0;
        rom_byte_n   <= !req_byte;
        rom_dq15_out <= req_byte & req_addr[0];
        rom_dq15_oe  <= req_byte;
      end else if (state == ST_WAIT && done) begin
        state     <= ST_IDLE;
        req_ready <= 1'b1;
        rsp_valid <= 1'b1;
        rsp_data  <= rom_byte_n ? rom_dq_in
                                : {{(DATA_W-BYTE_W){1'b0}}, rom_dq_in[BYTE_W-1:0]};
      end else if (idle_exp) begin
        rom_ce_n <= 1'b1;
        rom_oe_n <= 1'b1;
      end
    end
  end

  // R10: ROM inputs hold still for the whole wait
  a_r10_pins_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && $past(state == ST_WAIT)) |->
      ($stable(rom_addr) && $stable(rom_ce_n) && $stable(rom_byte_n) && $stable(rom_dq15_out)));
  // R9: data strobe lasts one cycle
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R2: controller is ready again when data is returned
  a_r2_ready_on_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);
  // R8: entering standby closes the page
  a_r8_standby_closes: assert property (@(posedge clk) disable iff (rst)
    $rose(rom_ce_n) |-> !page_open);
  // R8: output enable never active while chip is in standby
  a_r8_oe_with_ce: assert property (@(posedge clk) disable iff (rst)
    rom_ce_n |-> rom_oe_n);
  // R4: a page hit loads the short wait
  a_r4_short_wait: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> (wait_left == CNT_W'(PAGE_CYC)));
endmodule

// File: tb/tb_prom_page_rd.sv
module tb_prom_page_rd;
  localparam int CLK_PS = 5000;
  localparam int RAND_PS = 120000;
  localparam int PAGE_PS = 50000;
  localparam int IDLE = 4;
  localparam int RC = (RAND_PS + CLK_PS - 1) / CLK_PS;
  localparam int PC = (PAGE_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_byte = 1'b0;
  logic [19:0] req_addr = '0;
  logic req_ready, rsp_valid, rom_ce_n, rom_oe_n, rom_byte_n, rom_dq15_out, rom_dq15_oe;
  logic [15:0] rsp_data, rom_dq_in;
  logic [18:0] rom_addr;

  always #2.5ns clk = ~clk;

  prom_page_rd #(.CLK_PERIOD_PS(CLK_PS), .RAND_ACC_PS(RAND_PS), .PAGE_ACC_PS(PAGE_PS),
                 .IDLE_LIMIT(IDLE)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_byte_n(rom_byte_n),
    .rom_dq15_out(rom_dq15_out), .rom_dq15_oe(rom_dq15_oe), .rom_dq_in(rom_dq_in));

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rom_word(input logic [18:0] w);
    return w[15:0] ^ {w[18:16], w[12:0]} ^ 16'h3C5A;
  endfunction

  // Behavioural ROM: data appears only after the access times have elapsed
  logic [20:0] up_key_q;
  logic [2:0]  lo_key_q;
  int up_age = 0, lo_age = 0;
  logic [15:0] dq_q = 16'hDEAD;
  assign rom_dq_in = dq_q;

  always @(negedge clk) begin
    logic [20:0] uk;
    logic [2:0] lk;
    logic [15:0] w;
    uk = {rom_ce_n, rom_oe_n, rom_byte_n, rom_addr[18:2]};
    lk = {rom_addr[1:0], rom_dq15_oe & rom_dq15_out};
    if (uk !== up_key_q) begin up_age = 1; lo_age = 1; end
    else begin
      if (up_age < 1000) up_age++;
      if (lk !== lo_key_q) lo_age = 1; else if (lo_age < 1000) lo_age++;
    end
    up_key_q = uk;
    lo_key_q = lk;
    w = rom_word(rom_addr);
    if (rom_ce_n || rom_oe_n || up_age < RC || lo_age < PC) dq_q = 16'hDEAD;
    else if (!rom_byte_n) dq_q = {8'hC3, (rom_dq15_out ? w[15:8] : w[7:0])};
    else dq_q = w;
  end

  always @(posedge clk) cyc++;

  typedef struct {
    logic [15:0] data;
    int lat;
    int acc;
    string tag;
  } item_t;
  item_t q[$];

  // Monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q.size() == 0) chk(0, "R9 unexpected pulse", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(rsp_data === it.data, {it.tag, " data"}, rsp_data, it.data);
        chk(cyc - it.acc == it.lat, {it.tag, " latency"}, cyc - it.acc, it.lat);
      end
    end
  end

  bit have_prev = 0;
  logic [16:0] prev_up;
  bit prev_mode;

  task automatic issue(input logic [19:0] a, input bit bm, input int gap, input string tag);
    item_t it;
    bit hit;
    logic [15:0] w;
    while (!req_ready) @(negedge clk);
    repeat (gap) @(negedge clk);
    hit = have_prev && gap <= IDLE - 1 && prev_up == a[19:3] && prev_mode == bm;
    if (have_prev && gap >= IDLE) begin
      chk(rom_ce_n == 1'b1, "R8 standby ce", rom_ce_n, 1);
      chk(rom_oe_n == 1'b1, "R8 standby oe", rom_oe_n, 1);
    end
    w = rom_word(a[19:1]);
    it.data = bm ? {8'h00, (a[0] ? w[15:8] : w[7:0])} : w;
    it.lat = hit ? PC : RC;
    it.acc = cyc + 1;
    it.tag = hit ? {tag, " R4 hit"} : {tag, " R3 miss"};
    q.push_back(it);
    req_valid = 1'b1; req_addr = a; req_byte = bm;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy", req_ready, 0);
    chk(rom_addr == a[19:1], bm ? "R7 addr" : "R6 addr", rom_addr, a[19:1]);
    chk(rom_byte_n == !bm, bm ? "R7 byte_n" : "R6 byte_n", rom_byte_n, !bm);
    chk(rom_dq15_oe == bm, bm ? "R7 dq15 oe" : "R6 dq15 oe", rom_dq15_oe, bm);
    if (bm) chk(rom_dq15_out == a[0], "R7 dq15 value", rom_dq15_out, a[0]);
    have_prev = 1; prev_up = a[19:3]; prev_mode = bm;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rom_ce_n == 1 && rom_oe_n == 1, "R1 enables", {rom_ce_n, rom_oe_n}, 2'b11);
    chk(rom_byte_n == 1 && rom_dq15_oe == 0, "R1 mode", {rom_byte_n, rom_dq15_oe}, 2'b10);
    chk(rsp_valid == 0 && req_ready == 1, "R1 handshake", {rsp_valid, req_ready}, 2'b01);
    rst = 1'b0;
    @(negedge clk);
    issue(20'h01230, 0, 0, "word first");            // R3 R6
    issue(20'h01236, 0, 0, "word same page");        // R4
    issue(20'h01232, 0, IDLE - 1, "word last idle"); // R8 page kept
    issue(20'h01238, 0, 0, "new page");              // R3
    issue(20'h0123A, 1, 0, "R5 mode change");        // R5 R7
    issue(20'h0123F, 1, 1, "byte odd");              // R7 hit
    issue(20'h0123C, 1, 0, "byte even");             // R7
    issue(20'h0123E, 0, 0, "R5 back to word");       // R5
    issue(20'h0123C, 0, IDLE, "R8 after standby");   // R8
    issue(20'hFFFFF, 1, 0, "top byte");
    issue(20'hFFFF8, 1, 2, "top page first byte");
    for (int i = 0; i < 24; i++)
      issue(20'h5A000 + 20'(i * 3), i[2], i % 6, "sweep");
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(rsp_valid == 0, "R9 quiet", rsp_valid, 0);
    finished = 1;
    finish_run();
  end
endmodule